// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading translation tables from memory. Each table is 4 KB and holds 512 descriptors of 64 bits. The walk starts at the table whose address is presented on `base_i`. At each of four levels the walker takes nine bits of the virtual address as the entry index and issues one descriptor read.

Each descriptor it reads is sorted into one of three kinds. An invalid descriptor stops the walk with a translation fault. A table descriptor gives the address of the next table, and the walker moves one level down. A page descriptor is a leaf: it gives the physical page, and the walk finishes with that page and the descriptor's read, write and execute permission bits. Any descriptor that fits none of these kinds for its level also faults. The walker handles one translation at a time. A client presents a request while the walker is idle and waits for the one-cycle `done_o` pulse that carries the result.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, `done_o` is 0 and `mem_req_o` is 0.
- R2: A request is accepted only on a cycle with `req_valid_i` and `req_ready_o` both high. While a walk is in progress `req_ready_o` is low. A request presented during a walk produces no result and no memory read.
- R3: The first descriptor read of a walk goes to `{base_i[47:12], va[47:39], 3'b000}`. Bits 11..0 of `base_i` are ignored.
- R4: The reads at levels 1, 2 and 3 go to `{prev_desc[47:12], idx, 3'b000}`. Here `prev_desc` is the previous level's descriptor, and idx is va[38:30], va[29:21] or va[20:12] in that order.
- R5: At most one descriptor read is outstanding. `mem_req_o` is a one-cycle strobe and is not raised again until `mem_rvalid_i` has returned the previous descriptor.
- R6: A descriptor with bit 0 clear ends the walk with `fault_o`=1 and `fault_lvl_o` set to the level (0 to 3) at which it was read.
- R7: At levels 0 to 2, a descriptor with bits[1:0]=2'b11 is a table and the walk descends. At level 3, bits[1:0]=2'b11 is a page. Bits[1:0]=2'b01 at any level is a fault at that level.
- R8: A successful walk returns `pa_o` = `{leaf[47:12], va[11:0]}` with `fault_o`=0, after exactly four reads.
- R9: On success, `perm_r_o`, `perm_w_o` and `perm_x_o` equal leaf descriptor bits 2, 3 and 4. On a fault they are all 0.
- R10: `done_o` is high for exactly one cycle per accepted request. The walker is ready again in that same cycle.
- R11: Bits 63..48 of `req_va_i` have no effect on the reads issued or on the result.
- R12: Descriptor bits 63..48 and 11..5 have no effect on the addresses or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_va_i | input | 64 | Virtual address (bits 63..48 ignored) |
| base_i | input | 48 | Level 0 table address (bits 11..0 ignored) |
| mem_req_o | output | 1 | Descriptor read strobe |
| mem_addr_o | output | 48 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 64 | Descriptor data |
| done_o | output | 1 | Result valid, one cycle |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_lvl_o | output | 2 | Level at which the fault occurred |
| pa_o | output | 48 | Physical address |
| perm_r_o | output | 1 | Read permission of the leaf |
| perm_w_o | output | 1 | Write permission of the leaf |
| perm_x_o | output | 1 | Execute permission of the leaf |

## Verification
The bench faults a walk at levels 0, 1, 2 and 3 in turn, one fault cause per level. A walker with a wrong level counter or a wrong index slice reports the wrong `fault_lvl_o`, or reads a different number of descriptors than the walk needs. A valid descriptor with bit 1 clear is placed both at an upper level and at the leaf level; a decoder that treats bit 1 the same way at every level either descends past level 3 or accepts a block. The bench repeats a translation with all-ones upper address bits, junk base low bits and junk descriptor fields, which shows any leak of ignored bits. It also holds a second request high during a walk; a walker that accepts it would produce an extra result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PERM_R_BIT = 2;
  localparam int unsigned PERM_W_BIT = 3;
  localparam int unsigned PERM_X_BIT = 4;
  localparam int unsigned DESC_VALID_BIT = 0;
  localparam int unsigned DESC_KIND_BIT  = 1;

  typedef enum logic [1:0] {
    DK_INVALID,
    DK_TABLE,
    DK_PAGE,
    DK_BAD
  } desc_kind_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walk_state_e;
endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PG_OFS = 12,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  // level 0 takes the highest slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_arr[g] = va_i[PG_OFS + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign idx_o = idx_arr[lvl_i];

  logic unused_ofs;
  assign unused_ofs = ^va_i[PG_OFS-1:0];
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int unsigned DESC_W = 64,
  parameter int unsigned PA_W   = 48,
  parameter int unsigned PG_OFS = 12,
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned OA_W  = PA_W - PG_OFS
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output desc_kind_e        kind_o,
  output logic [OA_W-1:0]   oa_o,
  output perm_t             perm_o
);
  logic last_lvl;
  assign last_lvl = (lvl_i == LVL_W'(LEVELS-1));

  always_comb begin
    if (!desc_i[DESC_VALID_BIT])     kind_o = DK_INVALID;
    else if (!desc_i[DESC_KIND_BIT]) kind_o = DK_BAD;
    else if (last_lvl)               kind_o = DK_PAGE;
    else                             kind_o = DK_TABLE;
  end

  assign oa_o     = desc_i[PA_W-1:PG_OFS];
  assign perm_o.r = desc_i[PERM_R_BIT];
  assign perm_o.w = desc_i[PERM_W_BIT];
  assign perm_o.x = desc_i[PERM_X_BIT];

  logic unused_bits;
  assign unused_bits = ^{desc_i[DESC_W-1:PA_W], desc_i[PG_OFS-1:PERM_X_BIT+1]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 48,
  parameter int unsigned DESC_W = 64,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PG_OFS = 12,
  parameter int unsigned VIN_W  = 64,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned OA_W  = PA_W - PG_OFS,
  localparam int unsigned ENT_B = PG_OFS - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VIN_W-1:0]  req_va_i,
  input  logic [PA_W-1:0]   base_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [LVL_W-1:0]  fault_lvl_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o
);
  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic [OA_W-1:0]  tbl_q;
  logic             done_q, fault_q;
  logic [LVL_W-1:0] flvl_q;
  logic [PA_W-1:0]  pa_q;
  perm_t            perm_q;

  logic [IDX_W-1:0] idx;
  desc_kind_e       kind;
  logic [OA_W-1:0]  oa;
  perm_t            leaf_perm;

  ptw_idx_sel #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_OFS(PG_OFS)
  ) u_idx (
    .va_i (va_q),
    .lvl_i(lvl_q),
    .idx_o(idx)
  );

  ptw_desc_dec #(
    .DESC_W(DESC_W), .PA_W(PA_W), .PG_OFS(PG_OFS), .LEVELS(LEVELS)
  ) u_dec (
    .desc_i(mem_rdata_i),
    .lvl_i (lvl_q),
    .kind_o(kind),
    .oa_o  (oa),
    .perm_o(leaf_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      tbl_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_va_i[VA_W-1:0];
            tbl_q   <= base_i[PA_W-1:PG_OFS];
            lvl_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            unique case (kind)
              DK_TABLE: begin
                tbl_q   <= oa;
                lvl_q   <= lvl_q + LVL_W'(1);
                state_q <= ST_ISSUE;
              end
              DK_PAGE: begin
                done_q  <= 1'b1;
                fault_q <= 1'b0;
                flvl_q  <= lvl_q;
                pa_q    <= {oa, va_q[PG_OFS-1:0]};
                perm_q  <= leaf_perm;
                state_q <= ST_IDLE;
              end
              default: begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
                flvl_q  <= lvl_q;
                pa_q    <= '0;
                perm_q  <= '0;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign mem_addr_o  = {tbl_q, idx, {ENT_B{1'b0}}};
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign fault_lvl_o = flvl_q;
  assign pa_o        = pa_q;
  assign perm_r_o    = perm_q.r;
  assign perm_w_o    = perm_q.w;
  assign perm_x_o    = perm_q.x;

  logic unused_in;
  assign unused_in = ^{req_va_i[VIN_W-1:VA_W], base_i[PG_OFS-1:0]};
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [63:0] req_va_i,
  input logic [47:0] base_i,
  input logic        mem_req_o,
  input logic [47:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        done_o,
  input logic        fault_o,
  input logic [47:0] pa_o,
  input logic        perm_r_o,
  input logic        perm_w_o,
  input logic        perm_x_o
);
  logic        out_q, first_q;
  logic [35:0] base_cap;
  logic [8:0]  idx0_cap;
  logic [11:0] ofs_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= 1'b0;
      first_q  <= 1'b0;
      base_cap <= '0;
      idx0_cap <= '0;
      ofs_cap  <= '0;
    end else begin
      if (mem_req_o)         out_q <= 1'b1;
      else if (mem_rvalid_i) out_q <= 1'b0;
      if (req_valid_i && req_ready_o) begin
        first_q  <= 1'b1;
        base_cap <= base_i[47:12];
        idx0_cap <= req_va_i[47:39];
        ofs_cap  <= req_va_i[11:0];
      end else if (mem_req_o) begin
        first_q <= 1'b0;
      end
    end
  end

  AST_FIRST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && first_q) |-> (mem_addr_o == {base_cap, idx0_cap, 3'b000})); // R3
  AST_DESC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !out_q); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> !req_ready_o); // R2
  AST_PA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (pa_o[11:0] == ofs_cap)); // R8
  AST_FAULT_NO_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (!perm_r_o && !perm_w_o && !perm_x_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  logic unused_chk;
  assign unused_chk = ^{req_va_i[63:48], req_va_i[38:12], base_i[11:0], pa_o[47:12]};
endmodule

bind ptw_walker ptw_checker u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_va_i = '0;
  logic [47:0] base_i = '0;
  logic        mem_req_o;
  logic [47:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o, fault_o;
  logic [1:0]  fault_lvl_o;
  logic [47:0] pa_o;
  logic        perm_r_o, perm_w_o, perm_x_o;

  always #2 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_va_i(req_va_i), .base_i(base_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o), .pa_o(pa_o),
    .perm_r_o(perm_r_o), .perm_w_o(perm_w_o), .perm_x_o(perm_x_o)
  );

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int ovl = 0;
  int lat = 1;
  int pend = 0;
  logic [47:0] pend_addr;
  logic [63:0] mem [logic [47:0]];

  typedef struct {
    logic        flt;
    logic [1:0]  lvl;
    logic [47:0] pa;
    logic [2:0]  perm;  // {x,w,r}
    int          nrd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] daddr(input logic [47:0] tbl, input logic [8:0] idx);
    return {tbl[47:12], idx, 3'b000};
  endfunction
  function automatic logic [63:0] tdesc(input logic [47:0] nxt);
    return {16'hA5A5, nxt[47:12], 12'h7E3};  // junk in 63:48 and 11:5 (R12)
  endfunction
  function automatic logic [63:0] pdesc(input logic [47:0] pa, input logic [2:0] p);
    return {16'h5A5A, pa[47:12], 7'h55, p, 2'b11};
  endfunction

  task automatic map4(input logic [47:0] va, input logic [47:0] base, input logic [47:0] t1,
                      input logic [47:0] t2, input logic [47:0] t3, input logic [47:0] pa,
                      input logic [2:0] p);
    mem[daddr(base, va[47:39])] = tdesc(t1);
    mem[daddr(t1, va[38:30])]   = tdesc(t2);
    mem[daddr(t2, va[29:21])]   = tdesc(t3);
    mem[daddr(t3, va[20:12])]   = pdesc(pa, p);
  endtask

  // behavioural memory, latency set per walk
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rdata_i  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
          mem_rvalid_i = 1'b1;
        end
      end
      if (mem_req_o) begin
        if (pend > 0 || mem_rvalid_i) ovl++;
        reads++;
        pend_addr = mem_addr_o;
        pend = lat;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", 64'(pa_o), 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(fault_o == e.flt, "R6", {e.tag, " fault"}, 64'(fault_o), 64'(e.flt));
          if (e.flt)
            chk(fault_lvl_o == e.lvl, "R7", {e.tag, " fault level"}, 64'(fault_lvl_o), 64'(e.lvl));
          else
            chk(pa_o == e.pa, "R8", {e.tag, " pa"}, 64'(pa_o), 64'(e.pa));
          chk({perm_x_o, perm_w_o, perm_r_o} == e.perm, "R9", {e.tag, " perm"},
              64'({perm_x_o, perm_w_o, perm_r_o}), 64'(e.perm));
          chk(reads == e.nrd, "R4", {e.tag, " read count"}, 64'(reads), 64'(e.nrd));
          chk(ovl == 0, "R5", {e.tag, " overlapping read"}, 64'(ovl), 64'h0);
        end
      end
    end
  end

  task automatic walk(input logic [63:0] va, input logic [47:0] base, input int lt,
                      input exp_t e, input bit poke);
    while (!req_ready_o) @(negedge clk);
    lat = lt; reads = 0; ovl = 0;
    sb.push_back(e);
    req_va_i = va; base_i = base; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (poke) begin
      chk(!req_ready_o, "R2", "ready during walk", 64'(req_ready_o), 64'h0);
      req_va_i = 64'h0000_FF80_0000_0000;  // would fault at level 0 if taken
      req_valid_i = 1'b1;
      @(negedge clk); @(negedge clk);
      req_valid_i = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  localparam logic [47:0] B0 = 48'h0000_0010_0000;
  localparam logic [47:0] VA1 = 48'h1234_5678_9ABC;
  localparam logic [47:0] VA2 = 48'h1234_5678_AABC;

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'h1);
    chk(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 64'h0);
    chk(mem_req_o == 1'b0, "R1", "mem_req in reset", 64'(mem_req_o), 64'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    map4(VA1, B0, 48'h20_0000, 48'h30_0000, 48'h40_0000, 48'h00AB_CDE1_2000, 3'b101);
    map4(VA2, B0, 48'h20_0000, 48'h30_0000, 48'h40_0000, 48'h0000_7777_7000, 3'b010);
    // branch at idx0 = 0x080
    mem[daddr(B0, 9'h080)]          = tdesc(48'h50_0000);
    mem[daddr(48'h50_0000, 9'h000)] = tdesc(48'h60_0000);
    mem[daddr(48'h60_0000, 9'h000)] = 64'hFFFF_FFFF_FFFF_FFFE;  // invalid at level 2
    mem[daddr(48'h50_0000, 9'h001)] = 64'h0000_0000_7000_0001;  // valid, bit1 clear at level 1
    mem[daddr(48'h60_0000, 9'h001)] = tdesc(48'h70_0000);
    mem[daddr(48'h70_0000, 9'h000)] = 64'h0000_0000_9000_001D;  // valid, bit1 clear at level 3

    // R8 R9: full walk
    e = '{1'b0, 2'd0, {36'h00ABCDE12, VA1[11:0]}, 3'b101, 4, "R8 walk1"};
    walk({16'h0000, VA1}, B0, 1, e, 1'b0);
    // R11 R12 R3: upper VA bits set, junk base low bits, slower memory
    e = '{1'b0, 2'd0, {36'h000077777, VA2[11:0]}, 3'b010, 4, "R11 walk2"};
    walk({16'hFFFF, VA2}, B0 | 48'h123, 3, e, 1'b0);
    // R6: unmapped level-0 entry
    e = '{1'b1, 2'd0, 48'h0, 3'b000, 1, "R6 lvl0"};
    walk(64'h0000_FF80_0000_0000, B0, 1, e, 1'b0);
    // R6: invalid at level 2
    e = '{1'b1, 2'd2, 48'h0, 3'b000, 3, "R6 lvl2"};
    walk(64'h0000_4000_0000_0000, B0, 2, e, 1'b0);
    // R7: bit1 clear at level 1
    e = '{1'b1, 2'd1, 48'h0, 3'b000, 2, "R7 lvl1"};
    walk(64'h0000_4000_4000_0000, B0, 1, e, 1'b0);
    // R7: bit1 clear at leaf level
    e = '{1'b1, 2'd3, 48'h0, 3'b000, 4, "R7 lvl3"};
    walk(64'h0000_4000_0020_0000, B0, 2, e, 1'b0);
    // R2 R10: request held during walk is ignored, single result
    e = '{1'b0, 2'd0, {36'h00ABCDE12, VA1[11:0]}, 3'b101, 4, "R2 busy"};
    walk({16'h0000, VA1}, B0, 2, e, 1'b1);
    chk(req_ready_o == 1'b1, "R10", "ready after result", 64'(req_ready_o), 64'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule